// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage behind an 8-bit accumulator. In a single cycle it takes an instruction code, the current accumulator value and a second operand, and it forms the new accumulator value. The second operand has already been selected from a register, an immediate or memory. The block covers bitwise logic, addition and subtraction with or without a carry term, increment, decrement, complement, four rotate forms and a BCD correction step. It also handles three instructions that act on the carry bit alone.

The new accumulator value and its write request are produced combinationally from the inputs. The four status bits (carry, zero, sign, parity) sit in a register inside the block. They are loaded on the clock edge at which the issue strobe is high, and conditional branches test them. The carry term used by the add-with-carry, subtract-with-borrow, rotate-through-carry and decimal-adjust operations is always the registered carry flag. Fetching the operands and writing the accumulator back belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: Codes 0x80-0x87 give A AND operand, 0x88-0x8F give A OR operand and 0x90-0x97 give A XOR operand. Each asserts the accumulator write and updates zero, sign and parity. Carry keeps its old value.
- R2: Codes 0xA0-0xA7 give A + operand and codes 0xA8-0xAF give A + operand + carry. The result is taken modulo 256 and carry becomes the carry out of bit 7.
- R3: Codes 0xB0-0xB7 give A - operand and codes 0xB8-0xBF give A - operand - carry. The result is taken modulo 256 and carry becomes 1 exactly when a borrow occurs, that is, when the true difference is negative.
- R4: Code 0x9E gives A+1, code 0x9F gives A-1 and code 0x0F gives the bitwise inverse of A, each wrapping modulo 256. Carry keeps its old value; zero, sign and parity are updated.
- R5: Code 0x98 rotates A one place left and code 0x9A rotates it one place right, with carry unchanged. Code 0x99 gives {A[6:0],carry} and loads carry with A[7]. Code 0x9B gives {carry,A[7:1]} and loads carry with A[0].
- R6: Code 0x08 sets carry, 0x09 clears it and 0x0E inverts it. For these codes the accumulator write is low, the result output equals acc_i, and zero, sign and parity hold.
- R7: Code 0xFA is the BCD adjust. If A[3:0] > 9, 0x06 is added first. Then 0x60 is added if the high nibble of that sum is > 9, or carry was set, or the first add overflowed. The new carry is the old carry OR either overflow.
- R8: When the status bits are updated from a result, zero is 1 for a result of 0x00, sign is result bit 7, and parity is the XOR of all result bits (1 means an odd count of ones).
- R9: The status bits change only on a rising edge at which exec_i is high, and they are visible from that edge on. While exec_i is low they hold, whatever opcode_i carries.
- R10: Any code not listed above leaves the accumulator write low and acc_o equal to acc_i, and leaves all four status bits unchanged even when exec_i is high.
- R11: A synchronous active-high reset clears all four status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Issue strobe; loads the status bits on this edge |
| opcode_i | input | 8 | Instruction code |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand, already selected |
| acc_o | output | 8 | New accumulator value (combinational) |
| acc_wr_o | output | 1 | High when the code writes the accumulator |
| cy_o | output | 1 | Registered carry/borrow flag |
| z_o | output | 1 | Registered zero flag |
| s_o | output | 1 | Registered sign flag |
| p_o | output | 1 | Registered parity flag |

## Verification
The bench targets the carry corners: 0xFF+0x01 with and without incoming carry, 0x00-0x01, and a subtract-with-borrow whose operand is 0xFF. A design that inverted the borrow sense, or dropped the carry term in the with-carry forms, would show the wrong carry or a result that is off by one. The rotate-through-carry cases start with a carry that differs from the bit shifted out, so a plain rotate used in their place gives a wrong result bit and leaves carry unchanged. The decimal adjust is driven with 0x9A, where the low correction spills into a high nibble of 0xA and the sum wraps to zero with carry set, and with an incoming carry that alone forces the high correction. Unlisted codes and a dropped strobe are checked for leaving all status bits untouched, which a decoder that falls through to an arithmetic path would break.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int unsigned ACC_W  = 8;
    localparam int unsigned OPC_W  = 8;
    localparam int unsigned NIB_W  = ACC_W / 2;
    localparam int unsigned EXT_W  = ACC_W + 1;

    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [OPC_W-1:0] opc_t;

    localparam logic [NIB_W-1:0] BCD_MAX   = NIB_W'(9);
    localparam acc_t             LO_FIX    = ACC_W'(8'h06);
    localparam acc_t             HI_FIX    = ACC_W'(8'h60);

    typedef enum logic [4:0] {
        K_NONE, K_AND, K_OR, K_XOR,
        K_ADD, K_SUB, K_INC, K_DEC, K_DA,
        K_CPL, K_ROTL, K_ROTR,
        K_SETC, K_CLRC, K_CPLC
    } alu_kind_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      use_cy;
        logic      wr_acc;
        logic      wr_cy;
        logic      wr_zsp;
    } alu_ctl_t;

    typedef struct packed {
        logic cy;
        logic z;
        logic s;
        logic p;
    } alu_flags_t;

    function automatic alu_ctl_t decode_op(input opc_t op);
        alu_ctl_t c;
        c = '{kind: K_NONE, use_cy: 1'b0, wr_acc: 1'b0, wr_cy: 1'b0, wr_zsp: 1'b0};
        casez (op)
            8'b1000_0???: c.kind = K_AND;
            8'b1000_1???: c.kind = K_OR;
            8'b1001_0???: c.kind = K_XOR;
            8'b1010_????: begin c.kind = K_ADD; c.use_cy = op[3]; end
            8'b1011_????: begin c.kind = K_SUB; c.use_cy = op[3]; end
            8'h98:        c.kind = K_ROTL;
            8'h99:        begin c.kind = K_ROTL; c.use_cy = 1'b1; end
            8'h9A:        c.kind = K_ROTR;
            8'h9B:        begin c.kind = K_ROTR; c.use_cy = 1'b1; end
            8'h9E:        c.kind = K_INC;
            8'h9F:        c.kind = K_DEC;
            8'h0F:        c.kind = K_CPL;
            8'hFA:        c.kind = K_DA;
            8'h08:        c.kind = K_SETC;
            8'h09:        c.kind = K_CLRC;
            8'h0E:        c.kind = K_CPLC;
            default:      c.kind = K_NONE;
        endcase
        unique case (c.kind)
            K_NONE:               ;
            K_SETC, K_CLRC, K_CPLC: c.wr_cy = 1'b1;
            K_ADD, K_SUB, K_DA:   begin c.wr_acc = 1'b1; c.wr_cy = 1'b1; c.wr_zsp = 1'b1; end
            K_ROTL, K_ROTR:       begin c.wr_acc = 1'b1; c.wr_cy = c.use_cy; c.wr_zsp = 1'b1; end
            default:              begin c.wr_acc = 1'b1; c.wr_zsp = 1'b1; end
        endcase
        return c;
    endfunction

    function automatic logic odd_ones(input acc_t v);
        return ^v;
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  opc_t     opcode,
    output alu_ctl_t ctl
);
    always_comb ctl = decode_op(opcode);
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
(
    input  alu_kind_e kind,
    input  logic      use_cy,
    input  acc_t      a,
    input  acc_t      b,
    input  logic      cy_in,
    output acc_t      res,
    output logic      cy_out
);
    logic [EXT_W-1:0] sum_w, dif_w, lo_w, hi_w;
    logic             cin;
    logic             need_lo, need_hi;

    always_comb begin
        cin   = use_cy & cy_in;
        sum_w = {1'b0, a} + {1'b0, b} + EXT_W'(cin);
        dif_w = {1'b0, a} - {1'b0, b} - EXT_W'(cin);

        need_lo = a[NIB_W-1:0] > BCD_MAX;
        lo_w    = {1'b0, a} + (need_lo ? {1'b0, LO_FIX} : '0);
        need_hi = (lo_w[ACC_W-1:NIB_W] > BCD_MAX) | cy_in | lo_w[ACC_W];
        hi_w    = {1'b0, lo_w[ACC_W-1:0]} + (need_hi ? {1'b0, HI_FIX} : '0);
    end

    always_comb begin
        res    = a;
        cy_out = cy_in;
        unique case (kind)
            K_ADD: begin res = sum_w[ACC_W-1:0]; cy_out = sum_w[ACC_W]; end
            K_SUB: begin res = dif_w[ACC_W-1:0]; cy_out = dif_w[ACC_W]; end
            K_INC: res = a + ACC_W'(1);
            K_DEC: res = a - ACC_W'(1);
            K_DA:  begin
                res    = hi_w[ACC_W-1:0];
                cy_out = cy_in | lo_w[ACC_W] | hi_w[ACC_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
(
    input  alu_kind_e kind,
    input  logic      use_cy,
    input  acc_t      a,
    input  acc_t      b,
    input  logic      cy_in,
    output acc_t      res,
    output logic      cy_out
);
    logic fill_l, fill_r;

    always_comb begin
        fill_l = use_cy ? cy_in : a[ACC_W-1];
        fill_r = use_cy ? cy_in : a[0];
    end

    always_comb begin
        res    = a;
        cy_out = cy_in;
        unique case (kind)
            K_AND:  res = a & b;
            K_OR:   res = a | b;
            K_XOR:  res = a ^ b;
            K_CPL:  res = ~a;
            K_ROTL: begin
                res = {a[ACC_W-2:0], fill_l};
                if (use_cy) cy_out = a[ACC_W-1];
            end
            K_ROTR: begin
                res = {fill_r, a[ACC_W-1:1]};
                if (use_cy) cy_out = a[0];
            end
            K_SETC: cy_out = 1'b1;
            K_CLRC: cy_out = 1'b0;
            K_CPLC: cy_out = ~cy_in;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       wr_cy,
    input  logic       wr_zsp,
    input  acc_t       res,
    input  logic       cy_new,
    output alu_flags_t flags
);
    alu_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (en) begin
            if (wr_cy)  flags_q.cy <= cy_new;
            if (wr_zsp) begin
                flags_q.z <= (res == '0);
                flags_q.s <= res[ACC_W-1];
                flags_q.p <= odd_ones(res);
            end
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       exec_i,
    input  logic [7:0] opcode_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    output logic [7:0] acc_o,
    output logic       acc_wr_o,
    output logic       cy_o,
    output logic       z_o,
    output logic       s_o,
    output logic       p_o
);
    alu_ctl_t   ctl;
    alu_flags_t flags;
    acc_t       ar_res, bo_res, res;
    logic       ar_cy, bo_cy, cy_new, take_arith;

    acc_alu_decode u_dec (
        .opcode (opcode_i),
        .ctl    (ctl)
    );

    acc_alu_arith u_arith (
        .kind   (ctl.kind),
        .use_cy (ctl.use_cy),
        .a      (acc_i),
        .b      (opnd_i),
        .cy_in  (flags.cy),
        .res    (ar_res),
        .cy_out (ar_cy)
    );

    acc_alu_bitops u_bits (
        .kind   (ctl.kind),
        .use_cy (ctl.use_cy),
        .a      (acc_i),
        .b      (opnd_i),
        .cy_in  (flags.cy),
        .res    (bo_res),
        .cy_out (bo_cy)
    );

    always_comb begin
        take_arith = ctl.kind inside {K_ADD, K_SUB, K_INC, K_DEC, K_DA};
        res        = take_arith ? ar_res : bo_res;
        cy_new     = take_arith ? ar_cy  : bo_cy;
    end

    acc_alu_flagreg u_flags (
        .clk    (clk),
        .rst    (rst),
        .en     (exec_i),
        .wr_cy  (ctl.wr_cy),
        .wr_zsp (ctl.wr_zsp),
        .res    (res),
        .cy_new (cy_new),
        .flags  (flags)
    );

    assign acc_o    = ctl.wr_acc ? res : acc_i;
    assign acc_wr_o = ctl.wr_acc;
    assign cy_o     = flags.cy;
    assign z_o      = flags.z;
    assign s_o      = flags.s;
    assign p_o      = flags.p;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic       exec_i,
    input logic [7:0] opcode_i,
    input logic [7:0] acc_i,
    input logic [7:0] opnd_i,
    input logic [7:0] acc_o,
    input logic       acc_wr_o,
    input logic       cy_o,
    input logic       z_o,
    input logic       s_o,
    input logic       p_o
);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> $stable({cy_o, z_o, s_o, p_o}));

    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (exec_i && acc_wr_o) |=> (z_o == ($past(acc_o) == 8'h00)));

    p_sign_r8: assert property (@(posedge clk) disable iff (rst)
        (exec_i && acc_wr_o) |=> (s_o == $past(acc_o[7])));

    p_par_r8: assert property (@(posedge clk) disable iff (rst)
        (exec_i && acc_wr_o) |=> (p_o == ^$past(acc_o)));

    p_logic_cy_r1: assert property (@(posedge clk) disable iff (rst)
        (exec_i && opcode_i[7:3] inside {5'b10000, 5'b10001, 5'b10010}) |=> $stable(cy_o));

    p_add_r2: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == 8'hA0) |-> (acc_o == 8'(acc_i + opnd_i)));

    p_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == 8'h9E) |-> (acc_o == 8'(acc_i + 8'd1)));

    p_setc_r6: assert property (@(posedge clk) disable iff (rst)
        (exec_i && opcode_i == 8'h08) |=> (cy_o && $stable({z_o, s_o, p_o})));

    p_clrc_r6: assert property (@(posedge clk) disable iff (rst)
        (exec_i && opcode_i == 8'h09) |=> (!cy_o && $stable({z_o, s_o, p_o})));

    p_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_wr_o |-> (acc_o == acc_i));
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .exec_i   (exec_i),
    .opcode_i (opcode_i),
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .acc_o    (acc_o),
    .acc_wr_o (acc_wr_o),
    .cy_o     (cy_o),
    .z_o      (z_o),
    .s_o      (s_o),
    .p_o      (p_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_i = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opnd_i = 8'h00;
    logic [7:0] acc_o;
    logic       acc_wr_o, cy_o, z_o, s_o, p_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    // expected status bits, tracked by the bench
    logic m_cy = 0, m_z = 0, m_s = 0, m_p = 0;

    always #2.5 clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst(rst), .exec_i(exec_i), .opcode_i(opcode_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .acc_o(acc_o), .acc_wr_o(acc_wr_o),
        .cy_o(cy_o), .z_o(z_o), .s_o(s_o), .p_o(p_o)
    );

    function automatic logic ones_odd(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) if ((v >> i) & 1) n++;
        return (n % 2) == 1;
    endfunction

    // {result, wr, cy, z, s, p}; ucz = 1 means z/s/p follow the result
    task automatic model(input logic [7:0] op, input int a, input int b,
                         output int r, output logic wr, output logic cy,
                         output logic ucz);
        int t; logic c1;
        r = a; wr = 1; cy = m_cy; ucz = 1;
        if (op >= 8'h80 && op <= 8'h87)      r = a & b;
        else if (op >= 8'h88 && op <= 8'h8F) r = a | b;
        else if (op >= 8'h90 && op <= 8'h97) r = a ^ b;
        else if (op >= 8'hA0 && op <= 8'hAF) begin
            t = a + b + ((op >= 8'hA8) ? int'(m_cy) : 0);
            cy = (t > 255); r = t % 256;
        end else if (op >= 8'hB0 && op <= 8'hBF) begin
            t = a - b - ((op >= 8'hB8) ? int'(m_cy) : 0);
            cy = (t < 0); r = (t + 512) % 256;
        end else if (op == 8'h9E) r = (a + 1) % 256;
        else if (op == 8'h9F) r = (a + 255) % 256;
        else if (op == 8'h0F) r = 255 - a;
        else if (op == 8'h98) r = ((a * 2) % 256) + (a / 128);
        else if (op == 8'h9A) r = (a / 2) + ((a % 2) * 128);
        else if (op == 8'h99) begin r = ((a * 2) % 256) + int'(m_cy); cy = (a >= 128); end
        else if (op == 8'h9B) begin r = (a / 2) + int'(m_cy) * 128; cy = (a % 2) == 1; end
        else if (op == 8'hFA) begin
            t = a; c1 = 0;
            if ((a % 16) > 9) t = t + 6;
            if (t > 255) begin c1 = 1; t = t - 256; end
            if ((t / 16) > 9 || m_cy || c1) t = t + 96;
            cy = m_cy | c1 | (t > 255);
            r = t % 256;
        end else if (op == 8'h08 || op == 8'h09 || op == 8'h0E) begin
            wr = 0; ucz = 0;
            cy = (op == 8'h08) ? 1'b1 : (op == 8'h09) ? 1'b0 : ~m_cy;
        end else begin
            wr = 0; ucz = 0;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input int a, input int b,
                          input string req);
        int r; logic wr, cy, ucz;
        logic [3:0] ef;
        model(op, a, b, r, wr, cy, ucz);
        @(negedge clk);
        opcode_i = op; acc_i = 8'(a); opnd_i = 8'(b); exec_i = 1'b1;
        #1;
        check(acc_o == 8'(r) && acc_wr_o == wr, req, "result/wr",
              {acc_o, 3'b0, acc_wr_o}, {r[7:0], 3'b0, wr});
        ef = {cy, ucz ? (r == 0) : m_z, ucz ? r[7] : m_s, ucz ? ones_odd(r) : m_p};
        @(posedge clk); #1;
        exec_i = 1'b0;
        check({cy_o, z_o, s_o, p_o} == ef, req, "flags cy,z,s,p",
              {cy_o, z_o, s_o, p_o}, ef);
        {m_cy, m_z, m_s, m_p} = ef;
    endtask

    task automatic t_reset();
        check({cy_o, z_o, s_o, p_o} == 4'b0, "R11", "flags after reset",
              {cy_o, z_o, s_o, p_o}, 0);
    endtask

    task automatic t_logic();
        run_op(8'h08, 0, 0, "R6");          // carry=1 so R1 can show it is kept
        run_op(8'h80, 8'hF0, 8'h3C, "R1");  // AND -> 0x30
        run_op(8'h8E, 8'h81, 8'h02, "R1");  // OR  -> 0x83, sign set
        run_op(8'h96, 8'h5A, 8'h5A, "R1");  // XOR -> 0x00, zero
        run_op(8'h87, 8'h07, 8'h01, "R8");  // parity odd
    endtask

    task automatic t_add();
        run_op(8'h09, 0, 0, "R6");
        run_op(8'hA3, 8'hFF, 8'h01, "R2");  // wrap, carry out
        run_op(8'hAE, 8'hFF, 8'h00, "R2");  // with carry in -> 0x00, carry
        run_op(8'hA8, 8'h12, 8'h34, "R2");  // carry in 1 -> 0x47
        run_op(8'hA6, 8'h40, 8'h40, "R2");  // 0x80 no carry
    endtask

    task automatic t_sub();
        run_op(8'hB0, 8'h00, 8'h01, "R3");  // borrow -> 0xFF
        run_op(8'hBF, 8'h10, 8'hFF, "R3");  // borrow in, borrow out
        run_op(8'hB8, 8'h10, 8'h05, "R3");  // 0x10-5-1 -> 0x0A
        run_op(8'hB6, 8'h33, 8'h33, "R3");  // zero, no borrow
    endtask

    task automatic t_incdec();
        run_op(8'h08, 0, 0, "R6");
        run_op(8'h9E, 8'hFF, 0, "R4");      // wrap to 0, carry kept 1
        run_op(8'h9F, 8'h00, 0, "R4");      // wrap to 0xFF
        run_op(8'h0F, 8'hA5, 0, "R4");      // complement -> 0x5A
    endtask

    task automatic t_rotate();
        run_op(8'h09, 0, 0, "R6");
        run_op(8'h98, 8'h81, 0, "R5");      // -> 0x03, carry stays 0
        run_op(8'h9A, 8'h01, 0, "R5");      // -> 0x80
        run_op(8'h99, 8'h80, 0, "R5");      // carry 0 in, 1 out -> 0x00
        run_op(8'h9B, 8'h02, 0, "R5");      // carry 1 in -> 0x81, carry 0
        run_op(8'h99, 8'h41, 0, "R5");      // carry 0 -> 0x82
    endtask

    task automatic t_carry_ops();
        run_op(8'h0E, 8'h77, 0, "R6");      // invert carry, acc passes
        run_op(8'h0E, 8'h00, 0, "R6");
        run_op(8'h08, 8'h12, 0, "R6");
        run_op(8'h09, 8'h34, 0, "R6");
    endtask

    task automatic t_da();
        run_op(8'hFA, 8'h9A, 0, "R7");      // -> 0x00, carry set
        run_op(8'hFA, 8'h12, 0, "R7");      // carry in forces +0x60 -> 0x72
        run_op(8'h09, 0, 0, "R6");
        run_op(8'hFA, 8'h3C, 0, "R7");      // -> 0x42
        run_op(8'hFA, 8'h15, 0, "R7");      // untouched
        run_op(8'hFA, 8'hA0, 0, "R7");      // high fix -> 0x00, carry
    endtask

    task automatic t_unlisted();
        run_op(8'h00, 8'h00, 8'h55, "R10");
        run_op(8'h45, 8'h80, 8'h01, "R10");
        run_op(8'hFB, 8'h00, 8'h00, "R10");
        run_op(8'hD0, 8'h01, 8'h01, "R10");
    endtask

    task automatic t_hold();
        @(negedge clk);
        opcode_i = 8'hA0; acc_i = 8'hFF; opnd_i = 8'h01; exec_i = 1'b0;
        @(posedge clk); #1;
        check({cy_o, z_o, s_o, p_o} == {m_cy, m_z, m_s, m_p}, "R9",
              "flags with strobe low", {cy_o, z_o, s_o, p_o}, {m_cy, m_z, m_s, m_p});
        @(negedge clk); opcode_i = 8'h09;
        @(posedge clk); #1;
        check(cy_o == m_cy, "R9", "carry with strobe low", cy_o, m_cy);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_incdec();
        t_rotate();
        t_carry_ops();
        t_da();
        t_unlisted();
        t_hold();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule